// File: doc/BRIEF.md
# ASID-Tagged Set-Associative TLB Lookup

This block holds a small set-associative table of address translations. It returns the physical address for a virtual address, or a fault cause code, one cycle after the request. Each entry has a virtual page number, a physical page number, an 8-bit address-space identifier (ASID) and a 4-bit attribute. A lookup compares the addressed set in every way at once. It turns the ASID of the matching entry into a protection ring by searching four byte lanes of a ring register. It then checks the ring against the requester's privilege and the attribute against the access type.

Entries are loaded through a write port. The set index is taken from the low bits of the virtual page number. Reset clears every entry to ASID zero, which makes all of them invalid, and loads the ring register with its default value. A two-bit counter steps on request and names the way that the next refill should use. Page-table walking is left to logic outside the block.

Top module: `asid_tlb`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `refill_way` is 0. Every entry has ASID 0, so every lookup misses. The ring register reads 0x04030201: byte k, at bits 8k+7..8k, holds ASID k+1.
- R2: `rsp_valid` is 1 in the cycle after each cycle with `req_valid` high, and 0 otherwise. The response reflects the table as it stood in the request cycle.
- R3: Entry (way, set) hits when its stored VPN equals `req_vaddr[VA_W-1:PAGE_BITS]` and its ASID is nonzero. The set is the low log2(SETS) bits of the VPN. A write sends `wr_vpn` to the set chosen by its own low bits, in way `wr_way`.
- R4: With no hit, the cause is 16 for a fetch (`req_kind`=2) and 24 for a data access (load or store).
- R5: With two or more hitting ways, the cause is 17 for a fetch and 25 for a data access.
- R6: The ring is the lowest byte index k (0..3) of the ring register whose byte equals the hit entry's ASID. `ring_we` loads `ring_wdata` into that register. An ASID that matches no byte raises the privilege cause.
- R7: A single hit whose ring is numerically below `req_priv` faults with cause 18 (fetch) or 26 (data). Causes rank miss or multi-hit first, then privilege, then rights.
- R8: For attribute values below 12, read is allowed, bit 0 grants execute and bit 1 grants write. Bits 3:2 pick the cache mode, reported on `rsp_cache`: 0 gives bypass (1), 1 gives write-back (2), and 2 gives write-through (3). Attribute 13 allows read and write with cache mode isolate (4). Attributes 12, 14 and 15 allow nothing and report cache mode 0.
- R9: A data lookup drops execute and a fetch drops read and write. A load (`req_kind` 0 or 3) needs read and otherwise faults with 28. A store (1) needs write and otherwise faults with 29. A fetch (2) needs execute and otherwise faults with 20.
- R10: A lookup without fault returns `rsp_fault`=0, cause 0, `rsp_paddr` = {PPN, `req_vaddr[PAGE_BITS-1:0]`}, the ring, and the rights left after masking. On any fault, the paddress and rights read 0.
- R11: Each cycle with `refill_step` high advances a 2-bit counter by one, wrapping from 3 to 0. `refill_way` shows that counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write an entry |
| wr_way | input | WAY_W | Way to write |
| wr_vpn | input | VA_W-PAGE_BITS | Virtual page number (its low bits pick the set) |
| wr_ppn | input | PA_W-PAGE_BITS | Physical page number |
| wr_asid | input | 8 | Address-space ID, 0 = invalid |
| wr_attr | input | 4 | Attribute |
| ring_we | input | 1 | Load the ring register |
| ring_wdata | input | 32 | New ring register value |
| refill_step | input | 1 | Advance the refill-way counter |
| refill_way | output | 2 | Way named for the next refill |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | VA_W | Virtual address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 load |
| req_priv | input | 2 | Requester privilege index |
| rsp_valid | output | 1 | Response valid |
| rsp_fault | output | 1 | Lookup faulted |
| rsp_cause | output | 6 | Cause code, 0 when no fault |
| rsp_paddr | output | PA_W | Physical address |
| rsp_ring | output | 2 | Ring of the hit entry |
| rsp_rd | output | 1 | Read allowed |
| rsp_wr | output | 1 | Write allowed |
| rsp_ex | output | 1 | Execute allowed |
| rsp_cache | output | 3 | Cache mode |

## Verification
The bench builds the block with four ways, four sets, 32-bit addresses and 4 KiB pages. With four ways, duplicate entries can be placed in non-adjacent ways (0 and 2) to raise a multi-hit. A 2-bit way index also exactly spans the refill counter. The 12-bit offset lets the pass-through of the page offset show up in the physical address. The ring register is rewritten so that duplicate and unmatched byte lanes are both covered.

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int NWAYS     = 4,
  parameter int SETS      = 4,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  localparam int WAY_W    = (NWAYS > 1) ? $clog2(NWAYS) : 1,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PPN_W    = PA_W - PAGE_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [7:0]       wr_asid,
  input  logic [3:0]       wr_attr,
  input  logic             ring_we,
  input  logic [31:0]      ring_wdata,
  input  logic             refill_step,
  output logic [1:0]       refill_way,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic [1:0]       req_priv,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [5:0]       rsp_cause,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_ring,
  output logic             rsp_rd,
  output logic             rsp_wr,
  output logic             rsp_ex,
  output logic [2:0]       rsp_cache
);

  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;

  localparam logic [5:0] C_OK        = 6'd0;
  localparam logic [5:0] C_I_MISS    = 6'd16;
  localparam logic [5:0] C_I_MULTI   = 6'd17;
  localparam logic [5:0] C_I_PRIV    = 6'd18;
  localparam logic [5:0] C_I_PROHIB  = 6'd20;
  localparam logic [5:0] C_D_MISS    = 6'd24;
  localparam logic [5:0] C_D_MULTI   = 6'd25;
  localparam logic [5:0] C_D_PRIV    = 6'd26;
  localparam logic [5:0] C_LD_PROHIB = 6'd28;
  localparam logic [5:0] C_ST_PROHIB = 6'd29;

  localparam logic [2:0] CM_NONE   = 3'd0;
  localparam logic [2:0] CM_BYPASS = 3'd1;
  localparam logic [2:0] CM_WB     = 3'd2;
  localparam logic [2:0] CM_WT     = 3'd3;
  localparam logic [2:0] CM_ISO    = 3'd4;

  logic [VPN_W-1:0] e_vpn  [NWAYS][SETS];
  logic [PPN_W-1:0] e_ppn  [NWAYS][SETS];
  logic [7:0]       e_asid [NWAYS][SETS];
  logic [3:0]       e_attr [NWAYS][SETS];

  logic [31:0] ring_reg;
  logic [1:0]  refill_cnt;

  logic [IDX_W-1:0] wr_idx;
  assign wr_idx = wr_vpn[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < NWAYS; w++)
        for (int s = 0; s < SETS; s++) begin
          e_vpn[w][s]  <= '0;
          e_ppn[w][s]  <= '0;
          e_asid[w][s] <= 8'd0;
          e_attr[w][s] <= 4'd0;
        end
    end else if (wr_en && (int'(wr_way) < NWAYS)) begin
      e_vpn[wr_way][wr_idx]  <= wr_vpn;
      e_ppn[wr_way][wr_idx]  <= wr_ppn;
      e_asid[wr_way][wr_idx] <= wr_asid;
      e_attr[wr_way][wr_idx] <= wr_attr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_reg   <= 32'h0403_0201;
      refill_cnt <= 2'd0;
    end else begin
      if (ring_we)     ring_reg   <= ring_wdata;
      if (refill_step) refill_cnt <= refill_cnt + 2'd1;
    end
  end

  assign refill_way = refill_cnt;

  logic [VPN_W-1:0] q_vpn;
  logic [IDX_W-1:0] q_idx;
  logic             q_fetch, q_store;
  assign q_vpn   = req_vaddr[VA_W-1:PAGE_BITS];
  assign q_idx   = q_vpn[IDX_W-1:0];
  assign q_fetch = (req_kind == 2'd2);
  assign q_store = (req_kind == 2'd1);

  logic [NWAYS-1:0] hit_vec;
  for (genvar w = 0; w < NWAYS; w++) begin : g_way_cmp
    assign hit_vec[w] = (e_vpn[w][q_idx] == q_vpn) && (e_asid[w][q_idx] != 8'd0);
  end

  logic [WAY_W-1:0] sel_way;
  always_comb begin
    sel_way = '0;
    for (int w = NWAYS - 1; w >= 0; w--)
      if (hit_vec[w]) sel_way = WAY_W'(w);
  end

  logic [7:0]       sel_asid;
  logic [3:0]       sel_attr;
  logic [PPN_W-1:0] sel_ppn;
  assign sel_asid = e_asid[sel_way][q_idx];
  assign sel_attr = e_attr[sel_way][q_idx];
  assign sel_ppn  = e_ppn[sel_way][q_idx];

  logic [1:0] ring;
  logic       ring_ok;
  always_comb begin
    ring    = 2'd0;
    ring_ok = 1'b0;
    for (int k = 3; k >= 0; k--)
      if (ring_reg[8*k +: 8] == sel_asid) begin
        ring    = 2'(k);
        ring_ok = 1'b1;
      end
  end

  logic       a_rd, a_wr, a_ex;
  logic [2:0] a_cache;
  always_comb begin
    a_rd = 1'b0; a_wr = 1'b0; a_ex = 1'b0; a_cache = CM_NONE;
    if (sel_attr < 4'd12) begin
      a_rd = 1'b1;
      a_ex = sel_attr[0];
      a_wr = sel_attr[1];
      case (sel_attr[3:2])
        2'd0:    a_cache = CM_BYPASS;
        2'd1:    a_cache = CM_WB;
        default: a_cache = CM_WT;
      endcase
    end else if (sel_attr == 4'd13) begin
      a_rd = 1'b1; a_wr = 1'b1; a_cache = CM_ISO;
    end
  end

  logic m_rd, m_wr, m_ex, grant;
  assign m_rd  = a_rd && !q_fetch;
  assign m_wr  = a_wr && !q_fetch;
  assign m_ex  = a_ex && q_fetch;
  assign grant = q_fetch ? m_ex : (q_store ? m_wr : m_rd);

  logic [5:0] n_cause;
  always_comb begin
    if (hit_vec == '0)
      n_cause = q_fetch ? C_I_MISS : C_D_MISS;
    else if ($countones(hit_vec) > 1)
      n_cause = q_fetch ? C_I_MULTI : C_D_MULTI;
    else if (!ring_ok || (ring < req_priv))
      n_cause = q_fetch ? C_I_PRIV : C_D_PRIV;
    else if (!grant)
      n_cause = q_fetch ? C_I_PROHIB : (q_store ? C_ST_PROHIB : C_LD_PROHIB);
    else
      n_cause = C_OK;
  end

  logic n_ok;
  assign n_ok = (n_cause == C_OK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= C_OK;
      rsp_paddr <= '0;
      rsp_ring  <= 2'd0;
      rsp_rd    <= 1'b0;
      rsp_wr    <= 1'b0;
      rsp_ex    <= 1'b0;
      rsp_cache <= CM_NONE;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_fault <= !n_ok;
        rsp_cause <= n_cause;
        rsp_paddr <= n_ok ? {sel_ppn, req_vaddr[PAGE_BITS-1:0]} : '0;
        rsp_ring  <= ring;
        rsp_rd    <= n_ok && m_rd;
        rsp_wr    <= n_ok && m_wr;
        rsp_ex    <= n_ok && m_ex;
        rsp_cache <= n_ok ? a_cache : CM_NONE;
      end
    end
  end

  a_r2_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r10_offset_passes: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_fault || rsp_paddr[PAGE_BITS-1:0] == $past(req_vaddr[PAGE_BITS-1:0])));
  a_r9_fetch_no_rw: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd2) |=> (!rsp_rd && !rsp_wr));
  a_r9_data_no_ex: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind != 2'd2) |=> !rsp_ex);
  a_r10_fault_clears_rights: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && !rsp_rd && !rsp_wr && !rsp_ex));
  a_r11_refill_steps: assert property (@(posedge clk) disable iff (!rst_n)
    refill_step |=> (refill_way == $past(refill_way) + 2'd1));
  a_r11_refill_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !refill_step |=> $stable(refill_way));

endmodule

// File: tb/asid_tlb_tb.sv
module asid_tlb_tb;
  localparam int NWAYS = 4, SETS = 4, VA_W = 32, PA_W = 32, PAGE_BITS = 12;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0; logic [1:0] wr_way = 0; logic [19:0] wr_vpn = 0, wr_ppn = 0;
  logic [7:0] wr_asid = 0; logic [3:0] wr_attr = 0;
  logic ring_we = 0; logic [31:0] ring_wdata = 0;
  logic refill_step = 0; logic [1:0] refill_way;
  logic req_valid = 0; logic [31:0] req_vaddr = 0; logic [1:0] req_kind = 0, req_priv = 0;
  logic rsp_valid, rsp_fault; logic [5:0] rsp_cause; logic [31:0] rsp_paddr;
  logic [1:0] rsp_ring; logic rsp_rd, rsp_wr, rsp_ex; logic [2:0] rsp_cache;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  asid_tlb #(.NWAYS(NWAYS), .SETS(SETS), .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_way(wr_way), .wr_vpn(wr_vpn),
    .wr_ppn(wr_ppn), .wr_asid(wr_asid), .wr_attr(wr_attr), .ring_we(ring_we),
    .ring_wdata(ring_wdata), .refill_step(refill_step), .refill_way(refill_way),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind), .req_priv(req_priv),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr),
    .rsp_ring(rsp_ring), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_ex(rsp_ex), .rsp_cache(rsp_cache));

  task automatic chk(string req, string what, longint got, longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic put(logic [1:0] way, logic [19:0] vpn, logic [19:0] ppn, logic [7:0] asid, logic [3:0] attr);
    @(negedge clk);
    wr_en = 1; wr_way = way; wr_vpn = vpn; wr_ppn = ppn; wr_asid = asid; wr_attr = attr;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_ring(logic [31:0] v);
    @(negedge clk);
    ring_we = 1; ring_wdata = v;
    @(negedge clk);
    ring_we = 0;
  endtask

  task automatic look(logic [31:0] va, logic [1:0] kind, logic [1:0] priv);
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_kind = kind; req_priv = priv;
    @(negedge clk);
    req_valid = 0;
    chk("R2", "rsp_valid", rsp_valid, 1);
  endtask

  task automatic expect_ok(string req, logic [31:0] pa, logic [1:0] ring,
                           bit rd, bit wr, bit ex, logic [2:0] cm);
    chk(req, "fault", rsp_fault, 0);
    chk(req, "cause", rsp_cause, 0);
    chk(req, "paddr", rsp_paddr, pa);
    chk(req, "ring", rsp_ring, ring);
    chk(req, "rd", rsp_rd, rd);
    chk(req, "wr", rsp_wr, wr);
    chk(req, "ex", rsp_ex, ex);
    chk(req, "cache", rsp_cache, cm);
  endtask

  task automatic expect_fault(string req, logic [5:0] cause);
    chk(req, "fault", rsp_fault, 1);
    chk(req, "cause", rsp_cause, cause);
    chk(req, "paddr", rsp_paddr, 0);
  endtask

  task automatic t_reset();
    chk("R1", "rsp_valid", rsp_valid, 0);
    chk("R1", "refill_way", refill_way, 0);
    look(32'h0000_0123, 2'd0, 2'd0);
    expect_fault("R1", 6'd24);
    @(negedge clk);
    chk("R2", "rsp_valid idle", rsp_valid, 0);
    put(2'd3, 20'h00AA2, 20'h00777, 8'h03, 4'd5);
    look(32'h00AA_2010, 2'd0, 2'd2);
    expect_ok("R1", 32'h0077_7010, 2'd2, 1, 0, 0, 3'd2);
    put(2'd3, 20'h00AA2, 20'h0, 8'h00, 4'd0);
  endtask

  task automatic t_hit();
    put(2'd1, 20'h12345, 20'hABCDE, 8'h01, 4'd7);
    look(32'h1234_5678, 2'd0, 2'd0);
    expect_ok("R3", 32'hABCD_E678, 2'd0, 1, 1, 0, 3'd2);
    look(32'h1234_5FFF, 2'd1, 2'd0);
    expect_ok("R10", 32'hABCD_EFFF, 2'd0, 1, 1, 0, 3'd2);
    look(32'h1234_5000, 2'd2, 2'd0);
    expect_ok("R9", 32'hABCD_E000, 2'd0, 0, 0, 1, 3'd2);
    look(32'h1234_5004, 2'd3, 2'd0);
    expect_ok("R9", 32'hABCD_E004, 2'd0, 1, 1, 0, 3'd2);
    look(32'h1234_1678, 2'd0, 2'd0);
    expect_fault("R3", 6'd24);
    put(2'd1, 20'h12345, 20'hABCDE, 8'h00, 4'd7);
    look(32'h1234_5678, 2'd0, 2'd0);
    expect_fault("R3", 6'd24);
  endtask

  task automatic t_miss_multi();
    look(32'h7777_7000, 2'd2, 2'd0);
    expect_fault("R4", 6'd16);
    look(32'h7777_7000, 2'd1, 2'd0);
    expect_fault("R4", 6'd24);
    put(2'd0, 20'h55556, 20'h11111, 8'h01, 4'd3);
    put(2'd2, 20'h55556, 20'h22222, 8'h02, 4'd3);
    look(32'h5555_6000, 2'd0, 2'd0);
    expect_fault("R5", 6'd25);
    look(32'h5555_6000, 2'd2, 2'd0);
    expect_fault("R5", 6'd17);
    put(2'd2, 20'h55556, 20'h22222, 8'h00, 4'd3);
    look(32'h5555_6abc, 2'd0, 2'd0);
    expect_ok("R5", 32'h1111_1abc, 2'd0, 1, 1, 0, 3'd1);
  endtask

  task automatic t_ring();
    put(2'd0, 20'h30001, 20'h00301, 8'h04, 4'd3);
    put(2'd1, 20'h30002, 20'h00302, 8'h02, 4'd3);
    look(32'h3000_1000, 2'd0, 2'd3);
    expect_ok("R6", 32'h0030_1000, 2'd3, 1, 1, 0, 3'd1);
    look(32'h3000_2000, 2'd0, 2'd1);
    expect_ok("R7", 32'h0030_2000, 2'd1, 1, 1, 0, 3'd1);
    look(32'h3000_2000, 2'd1, 2'd2);
    expect_fault("R7", 6'd26);
    look(32'h3000_2000, 2'd2, 2'd3);
    expect_fault("R7", 6'd18);
    set_ring(32'h0202_0202);
    look(32'h3000_2000, 2'd0, 2'd0);
    expect_ok("R6", 32'h0030_2000, 2'd0, 1, 1, 0, 3'd1);
    look(32'h3000_1000, 2'd0, 2'd0);
    expect_fault("R6", 6'd26);
    set_ring(32'h0403_0201);
    put(2'd2, 20'h30003, 20'h00303, 8'h02, 4'd14);
    look(32'h3000_3000, 2'd0, 2'd3);
    expect_fault("R7", 6'd26);
  endtask

  task automatic t_attr();
    put(2'd3, 20'h40000, 20'h00400, 8'h01, 4'd0);
    look(32'h4000_0010, 2'd0, 2'd0);
    expect_ok("R8", 32'h0040_0010, 2'd0, 1, 0, 0, 3'd1);
    look(32'h4000_0010, 2'd1, 2'd0);
    expect_fault("R9", 6'd29);
    look(32'h4000_0010, 2'd2, 2'd0);
    expect_fault("R9", 6'd20);
    put(2'd3, 20'h40000, 20'h00400, 8'h01, 4'd9);
    look(32'h4000_0020, 2'd2, 2'd0);
    expect_ok("R8", 32'h0040_0020, 2'd0, 0, 0, 1, 3'd3);
    look(32'h4000_0020, 2'd0, 2'd0);
    expect_ok("R8", 32'h0040_0020, 2'd0, 1, 0, 0, 3'd3);
    put(2'd3, 20'h40000, 20'h00400, 8'h01, 4'd13);
    look(32'h4000_0030, 2'd1, 2'd0);
    expect_ok("R8", 32'h0040_0030, 2'd0, 1, 1, 0, 3'd4);
    look(32'h4000_0030, 2'd2, 2'd0);
    expect_fault("R9", 6'd20);
    put(2'd3, 20'h40000, 20'h00400, 8'h01, 4'd14);
    look(32'h4000_0040, 2'd0, 2'd0);
    expect_fault("R8", 6'd28);
    put(2'd3, 20'h40000, 20'h00400, 8'h01, 4'd12);
    look(32'h4000_0040, 2'd3, 2'd0);
    expect_fault("R8", 6'd28);
  endtask

  task automatic t_refill();
    logic [1:0] exp_way = 2'd0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      refill_step = 1;
      @(negedge clk);
      refill_step = 0;
      exp_way = exp_way + 2'd1;
      chk("R11", "refill_way", refill_way, exp_way);
    end
    @(negedge clk);
    chk("R11", "refill_way hold", refill_way, exp_way);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_hit();
    t_miss_multi();
    t_ring();
    t_attr();
    t_refill();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule